// File: doc/BRIEF.md
# Chien Search Bit Corrector

This block finishes the decode of one sector protected by a binary BCH code over GF(2^M). It is given the error locator polynomial sigma(x), the degree L of that polynomial and the correction strength t. It searches for the roots of sigma over a shortened codeword, turns each root into a byte address and a bit index, and flips that bit in the sector's data area or in the sector's parity area. Each flip uses a one-byte read-modify-write port. The syndrome and locator stages sit upstream and are not part of this block.

Before the search, the block reads the sector's parity bytes through the same port. If every one of them is 0xFF, the sector counts as freshly erased and nothing is corrected. During the search, the positions of the roots are stored. They are applied to memory only if the number of roots equals L. Otherwise the sector is reported as uncorrectable and memory is left untouched. The field degree M is a parameter, and the sector holds (M-12)*512 data bytes. With the default M=13, the primitive polynomial is x^13+x^4+x^3+x+1 and the sector holds 512 bytes.

Top module: `chien_corrector`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are 0. While idle, no memory access is made.
- R2: Bit position p (1-based) is in error exactly when sigma(alpha^p) = 0, where alpha is the root of the primitive polynomial. Only p from 1 to 8*SECTOR + M*t is examined. Roots outside that range are not counted.
- R3: A root p maps to byte (p-1)/8 and bit (p-1) mod 8. A byte below SECTOR gets that bit inverted at that address in the data area (`mem_area`=0). No other data byte changes.
- R4: A byte index b with SECTOR <= b < SECTOR + ceil(M*t/8) inverts the bit in parity byte b-SECTOR (`mem_area`=1).
- R5: When the number of roots found equals L, all of them are applied, `err_count` = L and `uncorrectable` = 0. Several flips that land in one byte all take effect.
- R6: When the scan ends with fewer than L roots, `uncorrectable` = 1 and `err_count` = 0, and no write is made.
- R7: If all ceil(M*t/8) parity bytes read 0xFF, the block reports `erased` = 1 and `err_count` = 0 and makes no write. A single non-0xFF byte anywhere in that range disables this bypass.
- R8: With L = 0, the block finishes with `err_count` = 0, `uncorrectable` = 0 and no write.
- R9: The scan stops as soon as the L-th root is found. It does not run to the end of the codeword.
- R10: A root whose byte index reaches SECTOR + ceil(M*t/8) raises `fault` and `uncorrectable`. This cannot occur inside the search range, so `fault` stays 0.
- R11: Memory port: a read returns `mem_rdata` one cycle later. A read and a write never share a cycle. Every write follows a read of the same area and address in the cycle before.
- R12: `done` is a one-cycle pulse while `busy` is 1. The result outputs hold until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sector; inputs are captured when idle |
| t_cap | input | TW | Correction strength t, 1..T_MAX |
| sig_deg | input | TW | Locator degree L, 0..t |
| sigma | input | (T_MAX+1)*M | Coefficient k at bits [k*M +: M] |
| mem_rd_en | output | 1 | Byte read request |
| mem_wr_en | output | 1 | Byte write request |
| mem_area | output | 1 | 0 = data area, 1 = parity area |
| mem_addr | output | AW | Byte address within the selected area |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd_en` |
| busy | output | 1 | Sector in progress |
| done | output | 1 | One-cycle completion pulse |
| err_count | output | TW | Number of bits corrected |
| uncorrectable | output | 1 | Root count differed from L, or fault |
| erased | output | 1 | Erased-sector bypass taken |
| fault | output | 1 | Root mapped beyond the parity area |

## Verification
The assertions assume three things about the inputs. First, t lies in 1..T_MAX and L does not exceed t. Second, the coefficients of sigma above degree L are zero. Third, the memory behind the port returns read data with one cycle of latency. The bench keeps to these assumptions by building every sigma as a product of (x + alpha^p) over a chosen set of distinct positions, so the degree given always matches the polynomial. It uses a registered byte memory model for both areas. The uncorrectable case is built by placing one factor's root beyond the search range, which keeps the polynomial legal.

// File: rtl/chien_pkg.sv
package chien_pkg;
  localparam int GF_MAXW = 16;
  typedef logic [GF_MAXW-1:0] gf_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ECHK, S_SCAN, S_ARD, S_AWR, S_FIN
  } cs_state_t;

  // Primitive polynomial for the supported field degrees.
  function automatic gf_t prim_poly(input int m);
    return (m == 14) ? gf_t'(16'h4443) : gf_t'(16'h201B);
  endfunction

  // Multiply in GF(2^m) modulo poly.
  function automatic gf_t gf_mul(input gf_t a, input gf_t b, input int m, input gf_t poly);
    gf_t acc;
    gf_t x;
    acc = '0;
    x   = a;
    for (int i = 0; i < GF_MAXW; i++) begin
      if (i < m && b[i]) acc = acc ^ x;
      x = x << 1;
      if (x[m]) x = x ^ poly;
    end
    return acc;
  endfunction

  // alpha^k for small k.
  function automatic gf_t gf_alpha_pow(input int k, input int m, input gf_t poly);
    gf_t r;
    r = gf_t'(1);
    for (int i = 0; i < 64; i++) begin
      if (i < k) r = gf_mul(r, gf_t'(2), m, poly);
    end
    return r;
  endfunction

  function automatic int parity_bytes(input int m, input int t);
    return (m * t + 7) / 8;
  endfunction
endpackage

// File: rtl/chien_eval.sv
// One register per locator coefficient; each step multiplies
// coefficient k by alpha^k, so the sum tracks sigma(alpha^step).
module chien_eval
  import chien_pkg::*;
#(
  parameter int M     = 13,
  parameter int T_MAX = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   step,
  input  logic [(T_MAX+1)*M-1:0] coef,
  output logic                   is_root
);
  localparam gf_t POLY = prim_poly(M);

  logic [M-1:0] term_q [T_MAX+1];

  generate
    for (genvar k = 0; k <= T_MAX; k++) begin : g_term
      localparam gf_t AK = gf_alpha_pow(k, M, POLY);
      logic [M-1:0] term_d;
      logic         term_en;
      gf_t          prod;

      assign term_en = load | step;
      assign prod    = gf_mul(gf_t'(term_q[k]), AK, M, POLY);

      always_comb begin
        if (load) term_d = coef[k*M +: M];
        else      term_d = prod[M-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       term_q[k] <= '0;
        else if (term_en) term_q[k] <= term_d;
      end
    end
  endgenerate

  logic [M-1:0] sum;
  always_comb begin
    sum = '0;
    for (int k = 0; k <= T_MAX; k++) sum = sum ^ term_q[k];
  end
  assign is_root = (sum == '0);
endmodule

// File: rtl/chien_root_store.sv
// Holds the positions of the roots found until they are applied.
module chien_root_store #(
  parameter int T_MAX = 8,
  parameter int PW    = 13,
  localparam int IW   = (T_MAX > 1) ? $clog2(T_MAX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [IW-1:0] wr_idx,
  input  logic [PW-1:0] wr_pos,
  input  logic [IW-1:0] rd_idx,
  output logic [PW-1:0] rd_pos
);
  logic [PW-1:0] slot_q [T_MAX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < T_MAX; i++) slot_q[i] <= '0;
    end else if (wr) begin
      slot_q[wr_idx] <= wr_pos;
    end
  end

  assign rd_pos = slot_q[rd_idx];
endmodule

// File: rtl/chien_corrector.sv
module chien_corrector
  import chien_pkg::*;
#(
  parameter int M      = 13,
  parameter int T_MAX  = 8,
  localparam int SECTOR = (M - 12) * 512,
  localparam int TW     = $clog2(T_MAX + 1),
  localparam int NMAX   = SECTOR * 8 + M * T_MAX,
  localparam int PW     = $clog2(NMAX + 1),
  localparam int BYW    = PW - 3,
  localparam int AW     = $clog2(SECTOR),
  localparam int EBMAX  = parity_bytes(M, T_MAX),
  localparam int IW     = $clog2(EBMAX + 1),
  localparam int SIW    = (T_MAX > 1) ? $clog2(T_MAX) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [TW-1:0]          t_cap,
  input  logic [TW-1:0]          sig_deg,
  input  logic [(T_MAX+1)*M-1:0] sigma,
  output logic                   mem_rd_en,
  output logic                   mem_wr_en,
  output logic                   mem_area,
  output logic [AW-1:0]          mem_addr,
  output logic [7:0]             mem_wdata,
  input  logic [7:0]             mem_rdata,
  output logic                   busy,
  output logic                   done,
  output logic [TW-1:0]          err_count,
  output logic                   uncorrectable,
  output logic                   erased,
  output logic                   fault
);
  cs_state_t      st_q, st_d;
  logic [TW-1:0]  t_q, t_d, deg_q, deg_d, cnt_q, cnt_d, aidx_q, aidx_d;
  logic [IW-1:0]  idx_q, idx_d;
  logic           chk_q, chk_d, ff_q, ff_d;
  logic [PW-1:0]  pos_q, pos_d;
  logic [TW-1:0]  rc_q, rc_d;
  logic           ru_q, ru_d, re_q, re_d, rf_q, rf_d;

  logic           ev_load, ev_step, is_root, st_wr;
  logic [PW-1:0]  sp, sp_m1, mt, nlen;
  logic [IW-1:0]  eb;
  logic [BYW-1:0] byt;
  logic [2:0]     bitn;
  logic           in_data, in_par;

  chien_eval #(.M(M), .T_MAX(T_MAX)) u_eval (
    .clk(clk), .rst_n(rst_n), .load(ev_load), .step(ev_step),
    .coef(sigma), .is_root(is_root)
  );

  chien_root_store #(.T_MAX(T_MAX), .PW(PW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr(st_wr), .wr_idx(cnt_q[SIW-1:0]),
    .wr_pos(pos_q), .rd_idx(aidx_q[SIW-1:0]), .rd_pos(sp)
  );

  // Geometry derived from the captured strength.
  assign mt      = PW'(M) * PW'(t_q);
  assign eb      = IW'((mt + PW'(7)) >> 3);
  assign nlen    = PW'(SECTOR * 8) + mt;
  assign sp_m1   = sp - PW'(1);
  assign byt     = sp_m1[PW-1:3];
  assign bitn    = sp_m1[2:0];
  assign in_data = byt < BYW'(SECTOR);
  assign in_par  = byt < (BYW'(SECTOR) + BYW'(eb));

  always_comb begin
    st_d = st_q; t_d = t_q; deg_d = deg_q; cnt_d = cnt_q; aidx_d = aidx_q;
    idx_d = idx_q; chk_d = 1'b0; ff_d = ff_q; pos_d = pos_q;
    rc_d = rc_q; ru_d = ru_q; re_d = re_q; rf_d = rf_q;
    ev_load = 1'b0; ev_step = 1'b0; st_wr = 1'b0;
    mem_rd_en = 1'b0; mem_wr_en = 1'b0; mem_area = 1'b0;
    mem_addr = '0; mem_wdata = '0;
    case (st_q)
      S_IDLE: if (start) begin
        t_d = t_cap; deg_d = sig_deg; cnt_d = '0; aidx_d = '0;
        idx_d = '0; ff_d = 1'b1; pos_d = '0;
        rc_d = '0; ru_d = 1'b0; re_d = 1'b0; rf_d = 1'b0;
        ev_load = 1'b1;
        st_d = S_ECHK;
      end
      S_ECHK: begin
        mem_area = 1'b1;
        mem_addr = AW'(idx_q);
        if (idx_q < eb) begin
          mem_rd_en = 1'b1;
          idx_d = idx_q + IW'(1);
        end
        chk_d = mem_rd_en;
        if (chk_q) ff_d = ff_q & (mem_rdata == 8'hFF);
        if (idx_q == eb && chk_q) begin
          if (ff_d) begin
            re_d = 1'b1; st_d = S_FIN;
          end else if (deg_q == '0) begin
            st_d = S_FIN;
          end else begin
            st_d = S_SCAN;
          end
        end
      end
      S_SCAN: begin
        ev_step = 1'b1;
        pos_d   = pos_q + PW'(1);
        if (is_root && pos_q != '0) begin
          st_wr = (cnt_q < TW'(T_MAX));
          cnt_d = cnt_q + TW'(1);
        end
        if (is_root && pos_q != '0 && cnt_d == deg_q) begin
          st_d = S_ARD;
        end else if (pos_q == nlen) begin
          ru_d = 1'b1; st_d = S_FIN;
        end
      end
      S_ARD: begin
        mem_area = ~in_data;
        mem_addr = in_data ? AW'(byt) : AW'(byt - BYW'(SECTOR));
        if (!in_par) begin
          rf_d = 1'b1; ru_d = 1'b1; st_d = S_FIN;
        end else begin
          mem_rd_en = 1'b1; st_d = S_AWR;
        end
      end
      S_AWR: begin
        mem_area  = ~in_data;
        mem_addr  = in_data ? AW'(byt) : AW'(byt - BYW'(SECTOR));
        mem_wr_en = 1'b1;
        mem_wdata = mem_rdata ^ (8'h01 << bitn);
        if (aidx_q + TW'(1) == cnt_q) begin
          rc_d = cnt_q; st_d = S_FIN;
        end else begin
          aidx_d = aidx_q + TW'(1); st_d = S_ARD;
        end
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; t_q <= '0; deg_q <= '0; cnt_q <= '0; aidx_q <= '0;
      idx_q <= '0; chk_q <= 1'b0; ff_q <= 1'b0; pos_q <= '0;
      rc_q <= '0; ru_q <= 1'b0; re_q <= 1'b0; rf_q <= 1'b0;
    end else begin
      st_q <= st_d; t_q <= t_d; deg_q <= deg_d; cnt_q <= cnt_d; aidx_q <= aidx_d;
      idx_q <= idx_d; chk_q <= chk_d; ff_q <= ff_d; pos_q <= pos_d;
      rc_q <= rc_d; ru_q <= ru_d; re_q <= re_d; rf_q <= rf_d;
    end
  end

  assign busy          = (st_q != S_IDLE);
  assign done          = (st_q == S_FIN);
  assign err_count     = rc_q;
  assign uncorrectable = ru_q;
  assign erased        = re_q;
  assign fault         = rf_q;
endmodule

// File: rtl/chien_corrector_chk.sv
module chien_corrector_chk #(
  parameter int AW = 9,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_rd_en,
  input logic          mem_wr_en,
  input logic          mem_area,
  input logic [AW-1:0] mem_addr,
  input logic [TW-1:0] err_count,
  input logic          uncorrectable,
  input logic          erased,
  input logic          fault
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd_en && !mem_wr_en));

  p_unc_no_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && uncorrectable) |-> (err_count == '0));

  p_erased_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && erased) |-> (err_count == '0 && !uncorrectable));

  p_no_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fault);

  p_rw_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  p_wr_after_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($past(mem_rd_en) && $past(mem_addr) == mem_addr
                   && $past(mem_area) == mem_area));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

bind chien_corrector chien_corrector_chk #(.AW(AW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_area(mem_area),
  .mem_addr(mem_addr), .err_count(err_count), .uncorrectable(uncorrectable),
  .erased(erased), .fault(fault)
);

// File: tb/tb_chien_corrector.sv
`timescale 1ns/1ps
module tb_chien_corrector;
  localparam int M = 13, T_MAX = 8, SEC = 512, TW = 4, AW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [TW-1:0] t_cap = '0, sig_deg = '0;
  logic [(T_MAX+1)*M-1:0] sigma = '0;
  logic mem_rd_en, mem_wr_en, mem_area;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic busy, done, uncorrectable, erased, fault;
  logic [TW-1:0] err_count;

  always #4 clk = ~clk;

  chien_corrector dut (
    .clk(clk), .rst_n(rst_n), .start(start), .t_cap(t_cap), .sig_deg(sig_deg),
    .sigma(sigma), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_area(mem_area), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .err_count(err_count),
    .uncorrectable(uncorrectable), .erased(erased), .fault(fault)
  );

  // Byte memory model, one cycle read latency.
  logic [7:0] dmem [SEC];
  logic [7:0] pmem [16];
  logic [7:0] dexp [SEC];
  logic [7:0] pexp [16];
  int wr_seen = 0;
  initial mem_rdata = '0;
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem_area ? pmem[mem_addr[3:0]] : dmem[mem_addr];
    if (mem_wr_en) begin
      wr_seen <= wr_seen + 1;
      if (mem_area) pmem[mem_addr[3:0]] <= mem_wdata;
      else          dmem[mem_addr]      <= mem_wdata;
    end
  end

  int n_chk = 0, n_fail = 0;
  int roots [8];
  int latency;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int gmul(input int a, input int b);
    int r = 0;
    for (int i = 0; i < 13; i++) begin
      if (b[i]) r = r ^ a;
      a = a << 1;
      if ((a & 'h2000) != 0) a = a ^ 'h201B;
    end
    return r;
  endfunction

  function automatic int apow(input int p);
    int r = 1;
    for (int i = 0; i < p; i++) begin
      r = r << 1;
      if ((r & 'h2000) != 0) r = r ^ 'h201B;
    end
    return r;
  endfunction

  task automatic init_mem(input logic [7:0] pfill);
    for (int i = 0; i < SEC; i++) begin
      dmem[i] = 8'((i * 37 + 11) & 8'hFF);
      dexp[i] = dmem[i];
    end
    for (int i = 0; i < 16; i++) begin
      pmem[i] = pfill;
      pexp[i] = pfill;
    end
  endtask

  task automatic expect_flip(input int p);
    int b = (p - 1) / 8;
    int bi = (p - 1) % 8;
    if (b < SEC) dexp[b] = dexp[b] ^ 8'(1 << bi);
    else         pexp[b - SEC] = pexp[b - SEC] ^ 8'(1 << bi);
  endtask

  function automatic int mem_diffs();
    int d = 0;
    for (int i = 0; i < SEC; i++) if (dmem[i] !== dexp[i]) d++;
    for (int i = 0; i < 16; i++) if (pmem[i] !== pexp[i]) d++;
    return d;
  endfunction

  // Build sigma = prod (x + alpha^p) over roots[0..n-1], start and wait.
  task automatic launch(input int t, input int deg, input int n);
    int c [9];
    int w0;
    for (int k = 0; k < 9; k++) c[k] = 0;
    c[0] = 1;
    for (int r = 0; r < n; r++) begin
      int a = apow(roots[r]);
      for (int k = 8; k >= 1; k--) c[k] = c[k-1] ^ gmul(a, c[k]);
      c[0] = gmul(a, c[0]);
    end
    @(negedge clk);
    for (int k = 0; k < 9; k++) sigma[k*M +: M] = c[k][M-1:0];
    t_cap = TW'(t); sig_deg = TW'(deg); start = 1'b1;
    w0 = wr_seen;
    @(negedge clk);
    start = 1'b0;
    latency = 1;
    while (!done && latency < 20000) begin
      @(negedge clk);
      latency++;
    end
    check("R12 done seen", int'(done), 1);
    check("R10 fault clear", int'(fault), 0);
    wr_seen = wr_seen - w0;
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 rd/wr", int'(mem_rd_en | mem_wr_en), 0);
  endtask

  task automatic t_data_and_parity_edges();
    init_mem(8'h00);
    roots[0] = 1; roots[1] = 4096; roots[2] = 4148;
    expect_flip(1); expect_flip(4096); expect_flip(4148);
    launch(4, 3, 3);
    check("R3 R4 memory after correction", mem_diffs(), 0);
    check("R5 count", int'(err_count), 3);
    check("R5 not uncorrectable", int'(uncorrectable), 0);
    @(negedge clk);
    check("R12 done one cycle", int'(done), 0);
    check("R12 result held", int'(err_count), 3);
  endtask

  task automatic t_parity_last_byte();
    init_mem(8'h5A);
    roots[0] = 100; roots[1] = 4097; roots[2] = 4200;
    expect_flip(100); expect_flip(4097); expect_flip(4200);
    launch(8, 3, 3);
    check("R4 parity bytes 0 and 12", mem_diffs(), 0);
    check("R5 count t8", int'(err_count), 3);
    check("R5 writes", wr_seen, 3);
  endtask

  task automatic t_same_byte();
    init_mem(8'h00);
    roots[0] = 9; roots[1] = 16;
    expect_flip(9); expect_flip(16);
    launch(2, 2, 2);
    check("R5 two flips in one byte", int'(dmem[1]), int'(dexp[1]));
    check("R5 count", int'(err_count), 2);
  endtask

  task automatic t_uncorrectable();
    init_mem(8'h00);
    roots[0] = 10; roots[1] = 5000;
    launch(4, 2, 2);
    check("R6 uncorrectable", int'(uncorrectable), 1);
    check("R6 count zero", int'(err_count), 0);
    check("R6 no writes", wr_seen, 0);
    check("R2 R6 memory untouched", mem_diffs(), 0);
  endtask

  task automatic t_erased();
    init_mem(8'h00);
    for (int i = 0; i < 4; i++) begin pmem[i] = 8'hFF; pexp[i] = 8'hFF; end
    roots[0] = 5;
    launch(2, 1, 1);
    check("R7 erased flag", int'(erased), 1);
    check("R7 count zero", int'(err_count), 0);
    check("R7 no writes", wr_seen, 0);
    check("R7 data untouched", mem_diffs(), 0);
    init_mem(8'h00);
    for (int i = 0; i < 4; i++) begin pmem[i] = 8'hFF; pexp[i] = 8'hFF; end
    pmem[3] = 8'h7F; pexp[3] = 8'h7F;
    expect_flip(5);
    launch(2, 1, 1);
    check("R7 last parity byte breaks bypass", int'(erased), 0);
    check("R7 R3 corrected instead", mem_diffs(), 0);
  endtask

  task automatic t_zero_degree();
    init_mem(8'h00);
    launch(1, 0, 0);
    check("R8 count", int'(err_count), 0);
    check("R8 not uncorrectable", int'(uncorrectable), 0);
    check("R8 no writes", wr_seen, 0);
  endtask

  task automatic t_early_stop();
    init_mem(8'h00);
    roots[0] = 3; roots[1] = 7;
    expect_flip(3); expect_flip(7);
    launch(8, 2, 2);
    check("R9 finished well before full scan", int'(latency < 60), 1);
    check("R9 memory", mem_diffs(), 0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data_and_parity_edges();
    t_parity_last_byte();
    t_same_byte();
    t_uncorrectable();
    t_erased();
    t_zero_degree();
    t_early_stop();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule